// File: doc/BRIEF.md
# Debug Memory-Access Command Sequencer

This block turns a single debug command into the exact ordered series of scan operations needed to control a halted 16-bit target through its test port. A command has a 3-bit code, a 16-bit address and a 16-bit data word. From these the sequencer produces 8-bit instruction scans, 16-bit data scans and level changes on a separate target clock line. It then returns the captured 16-bit word together with a one-cycle completion pulse. The six operations are halt, release, load program counter, wait for instruction fetch, memory read and memory write. Read and write choose a byte or a word control word from the address.

The scan engine sits outside the block. For each scan the sequencer raises a request carrying the scan kind and the outgoing value. The engine answers with a one-cycle acknowledge and the word it captured. The target clock is a plain registered output. The sequencer changes it only on its own clock-low and clock-high steps.

Top module: `dbg_mem_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `done`=0, `shift_req`=0, `tgt_clk`=1, `timeout`=0, `rdata`=0.
- R2: Read (code 4). Scan order:
  - tgt_clk low; instruction CTRL; data 0x2409 if the address is above 0x00FF, else 0x2419.
  - instruction ADDR; data = address.
  - instruction D2A; tgt_clk high, then low.
  - data 0x0000, whose captured word becomes `rdata`.
  - Default instruction codes: CTRL=0x13, ADDR=0x83, DATA=0x41, D2A=0x85, ACAP=0x84, CCAP=0x14.
- R3: Write (code 5). Scan order:
  - tgt_clk low; CTRL; data 0x2408 for a word address (above 0x00FF), else 0x2418.
  - ADDR; the address.
  - D2A; the data word; tgt_clk high.
  - Then the full R2 read of the same address, whose result is returned in `rdata`.
- R4: Halt (code 0): DATA; data 0x3FFF; tgt_clk low; CTRL; data 0x2409; tgt_clk high.
- R5: Release (code 1): tgt_clk low; CTRL; data 0x2401; ACAP; tgt_clk high.
- R6: Load program counter (code 2). The new value is taken from `cmd_addr`. Scan order:
  - CTRL; data 0x3401.
  - DATA; data 0x4030; tgt_clk low, then high.
  - data = new value; tgt_clk low.
  - ACAP; tgt_clk high, then low.
  - CTRL; data 0x2401.
- R7: Wait for fetch (code 3) scans CCAP, then polls by scanning data 0x0000. It ends when bit 7 of the captured word is 1. Otherwise it drives tgt_clk low, then high, before the next poll. The last captured word is returned in `rdata`.
- R8: A wait for fetch ends after max(`poll_limit`,1) polls with bit 7 clear. In that case `timeout` is 1 from the completion pulse until the next accepted command, which clears it.
- R9: A command is accepted only while `cmd_ready`=1. A `cmd_valid` while busy has no effect on the running sequence. Codes 6 and 7 are never accepted: no scan and no completion pulse follow.
- R10: `done` is high for exactly one cycle per accepted command. A raised `shift_req` keeps its kind and value unchanged until `shift_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cmd_valid | input | 1 | command offered |
| cmd_op | input | 3 | command code |
| cmd_addr | input | 16 | address or new program counter |
| cmd_data | input | 16 | write data |
| poll_limit | input | POLL_W | maximum fetch polls |
| cmd_ready | output | 1 | idle, able to accept |
| done | output | 1 | one-cycle completion pulse |
| rdata | output | 16 | last captured word |
| timeout | output | 1 | fetch wait gave up |
| shift_req | output | 1 | scan requested |
| shift_is_ir | output | 1 | 1 = 8-bit instruction scan, 0 = 16-bit data scan |
| shift_out | output | 16 | scan value (instruction in bits 7:0) |
| shift_ack | input | 1 | scan finished, one cycle |
| shift_in | input | 16 | captured scan word |
| tgt_clk | output | 1 | target clock line |

## Verification
The assertions check these properties on every cycle:
- a pending scan request holds its kind and value until it is acknowledged;
- an idle sequencer requests no scan and leaves the target clock alone;
- an accepted command makes the block busy;
- `done` never lasts two cycles;
- `timeout` rises only together with `done`.

Only the bench scenarios can show the rest. They compare each scan and each target-clock edge against a behavioural model of the six operations. They cover the byte/word control choice at addresses 0x00FF and 0x0100, the write readback, and fetch polls that succeed at various counts or run out. They also cover commands offered while busy and the two unused codes.

// File: rtl/dbg_mem_seq_pkg.sv
package dbg_mem_seq_pkg;

  localparam int DR_W  = 16;
  localparam int IR_W  = 8;
  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    OP_HALT      = 3'd0,
    OP_RELEASE   = 3'd1,
    OP_SETPC     = 3'd2,
    OP_WAITFETCH = 3'd3,
    OP_READ      = 3'd4,
    OP_WRITE     = 3'd5
  } op_e;

  localparam logic [2:0] OP_LAST = 3'd5;

  typedef enum logic [2:0] {
    ST_IR, ST_DR, ST_LO, ST_HI, ST_END, ST_LOOP
  } kind_e;

  typedef enum logic [1:0] {
    SRC_CONST, SRC_ADDR, SRC_DATA
  } src_e;

  typedef struct packed {
    kind_e           kind;
    src_e            src;
    logic            capture;
    logic            poll;
    logic [DR_W-1:0] value;
  } step_t;

  // control words placed on the target's control register
  localparam logic [DR_W-1:0] CW_RD_WORD  = 16'h2409;
  localparam logic [DR_W-1:0] CW_RD_BYTE  = 16'h2419;
  localparam logic [DR_W-1:0] CW_WR_WORD  = 16'h2408;
  localparam logic [DR_W-1:0] CW_WR_BYTE  = 16'h2418;
  localparam logic [DR_W-1:0] CW_RUN      = 16'h2401;
  localparam logic [DR_W-1:0] CW_FREE_LO  = 16'h3401;
  localparam logic [DR_W-1:0] OPC_SELFJMP = 16'h3FFF;
  localparam logic [DR_W-1:0] OPC_LOADPC  = 16'h4030;
  localparam logic [DR_W-1:0] BYTE_SPACE_TOP = 16'h00FF;

  localparam int FETCH_BIT = 7;

  // fixed step positions of the fetch-wait program
  localparam logic [IDX_W-1:0] WF_POLL_IDX = 5'd1;
  localparam logic [IDX_W-1:0] WF_END_IDX  = 5'd5;
  // write program re-enters the read program at this offset
  localparam logic [IDX_W-1:0] WR_READ_OFS = 5'd8;

  function automatic step_t mk(kind_e k, src_e s, logic cap, logic pl, logic [DR_W-1:0] v);
    step_t r;
    r.kind    = k;
    r.src     = s;
    r.capture = cap;
    r.poll    = pl;
    r.value   = v;
    return r;
  endfunction

  function automatic step_t s_ir(logic [IR_W-1:0] code);
    return mk(ST_IR, SRC_CONST, 1'b0, 1'b0, {{(DR_W-IR_W){1'b0}}, code});
  endfunction

  function automatic step_t s_dr(logic [DR_W-1:0] v);
    return mk(ST_DR, SRC_CONST, 1'b0, 1'b0, v);
  endfunction

  function automatic step_t s_src(src_e s);
    return mk(ST_DR, s, 1'b0, 1'b0, '0);
  endfunction

  function automatic step_t s_cap(logic pl);
    return mk(ST_DR, SRC_CONST, 1'b1, pl, '0);
  endfunction

  function automatic step_t s_ctl(kind_e k);
    return mk(k, SRC_CONST, 1'b0, 1'b0, '0);
  endfunction

endpackage

// File: rtl/dbg_seq_rom.sv
module dbg_seq_rom
  import dbg_mem_seq_pkg::*;
#(
  parameter logic [IR_W-1:0] IR_CTRL = 8'h13,
  parameter logic [IR_W-1:0] IR_ADDR = 8'h83,
  parameter logic [IR_W-1:0] IR_DATA = 8'h41,
  parameter logic [IR_W-1:0] IR_D2A  = 8'h85,
  parameter logic [IR_W-1:0] IR_ACAP = 8'h84,
  parameter logic [IR_W-1:0] IR_CCAP = 8'h14
) (
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  output step_t            step
);

  function automatic step_t read_step(logic [IDX_W-1:0] k, logic w);
    case (k)
      5'd0:    return s_ctl(ST_LO);
      5'd1:    return s_ir(IR_CTRL);
      5'd2:    return s_dr(w ? CW_RD_WORD : CW_RD_BYTE);
      5'd3:    return s_ir(IR_ADDR);
      5'd4:    return s_src(SRC_ADDR);
      5'd5:    return s_ir(IR_D2A);
      5'd6:    return s_ctl(ST_HI);
      5'd7:    return s_ctl(ST_LO);
      5'd8:    return s_cap(1'b0);
      default: return s_ctl(ST_END);
    endcase
  endfunction

  function automatic step_t write_step(logic [IDX_W-1:0] k, logic w);
    case (k)
      5'd0:    return s_ctl(ST_LO);
      5'd1:    return s_ir(IR_CTRL);
      5'd2:    return s_dr(w ? CW_WR_WORD : CW_WR_BYTE);
      5'd3:    return s_ir(IR_ADDR);
      5'd4:    return s_src(SRC_ADDR);
      5'd5:    return s_ir(IR_D2A);
      5'd6:    return s_src(SRC_DATA);
      5'd7:    return s_ctl(ST_HI);
      default: return read_step(k - WR_READ_OFS, w);
    endcase
  endfunction

  function automatic step_t halt_step(logic [IDX_W-1:0] k);
    case (k)
      5'd0:    return s_ir(IR_DATA);
      5'd1:    return s_dr(OPC_SELFJMP);
      5'd2:    return s_ctl(ST_LO);
      5'd3:    return s_ir(IR_CTRL);
      5'd4:    return s_dr(CW_RD_WORD);
      5'd5:    return s_ctl(ST_HI);
      default: return s_ctl(ST_END);
    endcase
  endfunction

  function automatic step_t release_step(logic [IDX_W-1:0] k);
    case (k)
      5'd0:    return s_ctl(ST_LO);
      5'd1:    return s_ir(IR_CTRL);
      5'd2:    return s_dr(CW_RUN);
      5'd3:    return s_ir(IR_ACAP);
      5'd4:    return s_ctl(ST_HI);
      default: return s_ctl(ST_END);
    endcase
  endfunction

  function automatic step_t setpc_step(logic [IDX_W-1:0] k);
    case (k)
      5'd0:    return s_ir(IR_CTRL);
      5'd1:    return s_dr(CW_FREE_LO);
      5'd2:    return s_ir(IR_DATA);
      5'd3:    return s_dr(OPC_LOADPC);
      5'd4:    return s_ctl(ST_LO);
      5'd5:    return s_ctl(ST_HI);
      5'd6:    return s_src(SRC_ADDR);
      5'd7:    return s_ctl(ST_LO);
      5'd8:    return s_ir(IR_ACAP);
      5'd9:    return s_ctl(ST_HI);
      5'd10:   return s_ctl(ST_LO);
      5'd11:   return s_ir(IR_CTRL);
      5'd12:   return s_dr(CW_RUN);
      default: return s_ctl(ST_END);
    endcase
  endfunction

  function automatic step_t fetch_step(logic [IDX_W-1:0] k);
    case (k)
      5'd0:    return s_ir(IR_CCAP);
      5'd1:    return s_cap(1'b1);
      5'd2:    return s_ctl(ST_LO);
      5'd3:    return s_ctl(ST_HI);
      5'd4:    return s_ctl(ST_LOOP);
      default: return s_ctl(ST_END);
    endcase
  endfunction

  always_comb begin
    case (op)
      OP_HALT:      step = halt_step(idx);
      OP_RELEASE:   step = release_step(idx);
      OP_SETPC:     step = setpc_step(idx);
      OP_WAITFETCH: step = fetch_step(idx);
      OP_READ:      step = read_step(idx, wide);
      OP_WRITE:     step = write_step(idx, wide);
      default:      step = s_ctl(ST_END);
    endcase
  end

endmodule

// File: rtl/dbg_shift_port.sv
module dbg_shift_port
  import dbg_mem_seq_pkg::*;
(
  input  logic            running,
  input  step_t           step,
  input  logic [DR_W-1:0] addr,
  input  logic [DR_W-1:0] data,
  output logic            req,
  output logic            is_ir,
  output logic [DR_W-1:0] out_val
);

  always_comb begin
    req   = running && ((step.kind == ST_IR) || (step.kind == ST_DR));
    is_ir = (step.kind == ST_IR);
    case (step.src)
      SRC_ADDR: out_val = addr;
      SRC_DATA: out_val = data;
      default:  out_val = step.value;
    endcase
  end

endmodule

// File: rtl/dbg_poll_ctr.sv
module dbg_poll_ctr #(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [POLL_W-1:0] limit,
  output logic              last
);

  logic [POLL_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    // the poll now completing is the final one allowed
    last   = ({1'b0, cnt_q} + {{POLL_W{1'b0}}, 1'b1}) >= {1'b0, limit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dbg_mem_seq_pkg::*;
#(
  parameter int               POLL_W  = 8,
  parameter logic [IR_W-1:0]  IR_CTRL = 8'h13,
  parameter logic [IR_W-1:0]  IR_ADDR = 8'h83,
  parameter logic [IR_W-1:0]  IR_DATA = 8'h41,
  parameter logic [IR_W-1:0]  IR_D2A  = 8'h85,
  parameter logic [IR_W-1:0]  IR_ACAP = 8'h84,
  parameter logic [IR_W-1:0]  IR_CCAP = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DR_W-1:0]   cmd_addr,
  input  logic [DR_W-1:0]   cmd_data,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              cmd_ready,
  output logic              done,
  output logic [DR_W-1:0]   rdata,
  output logic              timeout,
  output logic              shift_req,
  output logic              shift_is_ir,
  output logic [DR_W-1:0]   shift_out,
  input  logic              shift_ack,
  input  logic [DR_W-1:0]   shift_in,
  output logic              tgt_clk
);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e            state_q, state_d;
  op_e               op_q, op_d;
  logic [DR_W-1:0]   addr_q, addr_d;
  logic [DR_W-1:0]   data_q, data_d;
  logic [POLL_W-1:0] limit_q, limit_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              tclk_q, tclk_d;
  logic [DR_W-1:0]   rdata_q, rdata_d;
  logic              tmo_pend_q, tmo_pend_d;
  logic              timeout_q, timeout_d;
  logic              done_q, done_d;

  step_t step;
  logic  running, wide, accept, op_legal, poll_inc, poll_last;

  assign running  = (state_q == S_RUN);
  assign wide     = (addr_q > BYTE_SPACE_TOP);
  assign op_legal = (cmd_op <= OP_LAST);
  assign accept   = (state_q == S_IDLE) && cmd_valid && op_legal;
  assign poll_inc = running && step.poll && shift_ack;

  dbg_seq_rom #(
    .IR_CTRL(IR_CTRL), .IR_ADDR(IR_ADDR), .IR_DATA(IR_DATA),
    .IR_D2A(IR_D2A),   .IR_ACAP(IR_ACAP), .IR_CCAP(IR_CCAP)
  ) u_rom (
    .op   (op_q),
    .idx  (idx_q),
    .wide (wide),
    .step (step)
  );

  dbg_shift_port u_port (
    .running (running),
    .step    (step),
    .addr    (addr_q),
    .data    (data_q),
    .req     (shift_req),
    .is_ir   (shift_is_ir),
    .out_val (shift_out)
  );

  dbg_poll_ctr #(.POLL_W(POLL_W)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (poll_inc),
    .limit (limit_q),
    .last  (poll_last)
  );

  // next-state
  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    addr_d     = addr_q;
    data_d     = data_q;
    limit_d    = limit_q;
    idx_d      = idx_q;
    tclk_d     = tclk_q;
    rdata_d    = rdata_q;
    tmo_pend_d = tmo_pend_q;
    timeout_d  = timeout_q;
    done_d     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d    = S_RUN;
          op_d       = op_e'(cmd_op);
          addr_d     = cmd_addr;
          data_d     = cmd_data;
          limit_d    = poll_limit;
          idx_d      = '0;
          tmo_pend_d = 1'b0;
          timeout_d  = 1'b0;
        end
      end
      S_RUN: begin
        case (step.kind)
          ST_IR, ST_DR: begin
            if (shift_ack) begin
              idx_d = idx_q + 1'b1;
              if (step.capture) rdata_d = shift_in;
              if (step.poll) begin
                if (shift_in[FETCH_BIT]) begin
                  idx_d = WF_END_IDX;
                end else if (poll_last) begin
                  idx_d      = WF_END_IDX;
                  tmo_pend_d = 1'b1;
                end
              end
            end
          end
          ST_LO: begin
            tclk_d = 1'b0;
            idx_d  = idx_q + 1'b1;
          end
          ST_HI: begin
            tclk_d = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
          ST_LOOP: idx_d = WF_POLL_IDX;
          default: begin
            state_d   = S_IDLE;
            done_d    = 1'b1;
            timeout_d = tmo_pend_q;
          end
        endcase
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_q       <= OP_HALT;
      addr_q     <= '0;
      data_q     <= '0;
      limit_q    <= '0;
      idx_q      <= '0;
      tclk_q     <= 1'b1;
      rdata_q    <= '0;
      tmo_pend_q <= 1'b0;
      timeout_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      op_q       <= op_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      limit_q    <= limit_d;
      idx_q      <= idx_d;
      tclk_q     <= tclk_d;
      rdata_q    <= rdata_d;
      tmo_pend_q <= tmo_pend_d;
      timeout_q  <= timeout_d;
      done_q     <= done_d;
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign timeout   = timeout_q;
  assign tgt_clk   = tclk_q;

endmodule

// File: rtl/dbg_mem_seq_chk.sv
module dbg_mem_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        cmd_ready,
  input logic        done,
  input logic        timeout,
  input logic        shift_req,
  input logic        shift_is_ir,
  input logic [15:0] shift_out,
  input logic        shift_ack,
  input logic        tgt_clk
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_req && !shift_ack) |=> (shift_req && $stable(shift_out) && $stable(shift_is_ir)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_no_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !shift_req);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && (cmd_op <= 3'd5)) |=> !cmd_ready);

  p_idle_clk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(tgt_clk));

  p_timeout_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

endmodule

bind dbg_mem_seq dbg_mem_seq_chk u_chk (.*);

// File: tb/dbg_mem_seq_test.sv
module dbg_mem_seq_test;

  localparam int POLL_W = 8;

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_addr, cmd_data;
  logic [POLL_W-1:0] poll_limit;
  logic        cmd_ready, done, timeout;
  logic [15:0] rdata;
  logic        shift_req, shift_is_ir, shift_ack;
  logic [15:0] shift_out, shift_in;
  logic        tgt_clk;

  dbg_mem_seq #(.POLL_W(POLL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .poll_limit(poll_limit),
    .cmd_ready(cmd_ready), .done(done), .rdata(rdata), .timeout(timeout),
    .shift_req(shift_req), .shift_is_ir(shift_is_ir), .shift_out(shift_out),
    .shift_ack(shift_ack), .shift_in(shift_in), .tgt_clk(tgt_clk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // instruction codes per R2
  localparam int I_CTRL = 'h13, I_ADDR = 'h83, I_DATA = 'h41;
  localparam int I_D2A  = 'h85, I_ACAP = 'h84, I_CCAP = 'h14;
  localparam int EV_IR = 0, EV_DR = 1, EV_EDGE = 2;

  int compared = 0, mismatched = 0;
  int exp_kind[$], exp_val[$], rsp_q[$];
  string exp_tag[$];
  int exp_rdata, exp_tmo;
  string cur_tag;
  int model_tclk;
  int tap_lat = 0, tap_wait = 0;
  int done_cnt = 0, req_cycles = 0, cycles = 0;
  logic prev_tclk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // ---------- behavioural model ----------
  function automatic void m_ir(int c);
    exp_kind.push_back(EV_IR); exp_val.push_back(c); exp_tag.push_back(cur_tag);
  endfunction
  function automatic void m_dr(int v, int rsp);
    exp_kind.push_back(EV_DR); exp_val.push_back(v); exp_tag.push_back(cur_tag);
    rsp_q.push_back(rsp);
  endfunction
  function automatic void m_clk(int lvl);
    if (model_tclk != lvl) begin
      exp_kind.push_back(EV_EDGE); exp_val.push_back(lvl); exp_tag.push_back(cur_tag);
    end
    model_tclk = lvl;
  endfunction

  function automatic void m_read(int a, int r);
    m_clk(0); m_ir(I_CTRL); m_dr(a > 'hFF ? 'h2409 : 'h2419, 'h1111);
    m_ir(I_ADDR); m_dr(a, 'h2222); m_ir(I_D2A);
    m_clk(1); m_clk(0); m_dr(0, r);
    exp_rdata = r;
  endfunction

  // ---------- scan engine model and monitor ----------
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (tgt_clk !== prev_tclk) begin
        if (exp_kind.size() == 0)
          chk(0, "R9 unexpected clock edge", tgt_clk, prev_tclk);
        else begin
          int k, v; string t;
          k = exp_kind.pop_front(); v = exp_val.pop_front(); t = exp_tag.pop_front();
          chk(k == EV_EDGE && v == tgt_clk, {t, " clock edge"}, {k, 4'(tgt_clk)}, {k, 4'(v)});
        end
      end
      prev_tclk = tgt_clk;
      if (shift_req) req_cycles++;
      if (shift_ack) shift_ack = 1'b0;
      else if (shift_req) begin
        if (tap_wait < tap_lat) tap_wait++;
        else begin
          int k, v; string t;
          tap_wait = 0;
          if (exp_kind.size() == 0) begin
            chk(0, "R9 unexpected scan", shift_out, 0);
            shift_in = 16'h0;
          end else begin
            k = exp_kind.pop_front(); v = exp_val.pop_front(); t = exp_tag.pop_front();
            chk(k == (shift_is_ir ? EV_IR : EV_DR) && v == shift_out, {t, " scan"},
                shift_out, v);
            shift_in = (!shift_is_ir && rsp_q.size() > 0) ? 16'(rsp_q.pop_front()) : 16'h0;
          end
          shift_ack = 1'b1;
        end
      end
      if (done) begin
        done_cnt++;
        chk(exp_kind.size() == 0, {cur_tag, " all steps before done"}, exp_kind.size(), 0);
        chk(rdata == exp_rdata[15:0], {cur_tag, " rdata"}, rdata, exp_rdata);
        chk(timeout == exp_tmo[0], {cur_tag, " R8 timeout flag"}, timeout, exp_tmo);
      end
    end
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic run_cmd(input int op, input int a, input int d, input int lim,
                         input bit poke_busy);
    int n;
    while (!cmd_ready) @(negedge clk);
    done_cnt = 0;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 16'(a); cmd_data = 16'(d);
    poll_limit = POLL_W'(lim);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 16'h0BAD;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {cur_tag, " R10 one done pulse"}, done_cnt, 1);
  endtask

  task automatic do_read(input int a, input int r);
    cur_tag = "R2 read"; exp_tmo = 0;
    m_read(a, r);
    run_cmd(4, a, 0, 0, 0);
  endtask

  task automatic do_write(input int a, input int d, input int r);
    cur_tag = "R3 write"; exp_tmo = 0;
    m_clk(0); m_ir(I_CTRL); m_dr(a > 'hFF ? 'h2408 : 'h2418, 'h3333);
    m_ir(I_ADDR); m_dr(a, 'h4444); m_ir(I_D2A); m_dr(d, 'h5555); m_clk(1);
    m_read(a, r);
    run_cmd(5, a, d, 0, 0);
  endtask

  task automatic do_fetch(input int lim, input int hit_at);
    int maxp;
    cur_tag = lim == 0 ? "R8 fetch limit0" : "R7 fetch";
    maxp = lim < 1 ? 1 : lim;
    exp_tmo = 1;
    m_ir(I_CCAP);
    for (int i = 0; i < maxp; i++) begin
      if (i == hit_at) begin
        m_dr(0, 'h00C5 + i); exp_rdata = 'h00C5 + i; exp_tmo = 0; break;
      end
      m_dr(0, 'h0135 + i); exp_rdata = 'h0135 + i;
      if (i + 1 < maxp) begin m_clk(0); m_clk(1); end
    end
    run_cmd(3, 0, 0, lim, 0);
  endtask

  initial begin
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0; poll_limit = 0;
    shift_ack = 0; shift_in = 0;
    model_tclk = 1; exp_rdata = 0; exp_tmo = 0; cur_tag = "init";
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    prev_tclk = tgt_clk;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    chk(done == 0 && shift_req == 0, "R1 done/shift_req", {done, shift_req}, 0);
    chk(tgt_clk == 1, "R1 tgt_clk", tgt_clk, 1);
    chk(timeout == 0 && rdata == 0, "R1 timeout/rdata", {timeout, rdata}, 0);

    // R4 halt
    cur_tag = "R4 halt"; exp_tmo = 0;
    m_ir(I_DATA); m_dr('h3FFF, 'h0); m_clk(0); m_ir(I_CTRL); m_dr('h2409, 'h0); m_clk(1);
    run_cmd(0, 0, 0, 0, 0);

    do_read('h0200, 'hCAFE);
    tap_lat = 2;
    do_read('h0042, 'h00AB);
    do_read('h00FF, 'h0077);
    do_read('h0100, 'h1234);
    tap_lat = 0;
    do_write('h0300, 'hBEEF, 'hBEEF);
    tap_lat = 1;
    do_write('h0010, 'h00EE, 'h00EE);

    // R5 release
    cur_tag = "R5 release"; exp_tmo = 0;
    m_clk(0); m_ir(I_CTRL); m_dr('h2401, 0); m_ir(I_ACAP); m_clk(1);
    run_cmd(1, 0, 0, 0, 0);

    // R6 load program counter
    cur_tag = "R6 setpc"; exp_tmo = 0;
    m_ir(I_CTRL); m_dr('h3401, 0); m_ir(I_DATA); m_dr('h4030, 0);
    m_clk(0); m_clk(1); m_dr('hF000, 0); m_clk(0); m_ir(I_ACAP);
    m_clk(1); m_clk(0); m_ir(I_CTRL); m_dr('h2401, 0);
    run_cmd(2, 'hF000, 'h5A5A, 0, 0);

    tap_lat = 0;
    do_fetch(5, 2);
    do_fetch(5, 0);
    do_fetch(3, 99);
    // R8 next accepted command clears timeout
    do_read('h0400, 'h0F0F);
    do_fetch(0, 99);

    // R9 command offered while busy is ignored
    cur_tag = "R9 busy read"; exp_tmo = 0;
    m_read('h0500, 'h9999);
    run_cmd(4, 'h0500, 0, 0, 1);

    // R9 unused codes are not accepted
    for (int c = 6; c < 8; c++) begin
      done_cnt = 0; req_cycles = 0;
      cmd_valid = 1'b1; cmd_op = 3'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(done_cnt == 0, "R9 unused code no done", done_cnt, 0);
      chk(req_cycles == 0, "R9 unused code no scan", req_cycles, 0);
      chk(cmd_ready == 1, "R9 unused code stays idle", cmd_ready, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule